// File: doc/BRIEF.md
# Core Event Latch and Nesting Controller

This block sits between the general-purpose event lines of a processor core and its pipeline. Each of the sixteen event levels is watched for rising edges. A detected edge is held in a latch register until the pipeline takes the event. A mask register and a single global enable decide which latched events may be offered. The controller offers at most one event at a time: the highest-priority one that is latched and allowed, and only if it outranks every event already in service.

When the pipeline acknowledges the offer, the event's bit is set in a pending register and its latch bit is dropped. The pending register records every event that is active or nested. A return-from-interrupt pulse retires the innermost (highest-priority) pending event, which resumes the event it had pre-empted. A further rising edge on a line whose event is in service is queued in the latch and offered again later.

Software reaches the latch, mask and pending registers through a simple select/write/read port. The pending register cannot be written. Latch bits can only be written while their mask bit is clear.

Top module: `evt_nest_ctrl`

## Requirements
- R1: While reset is held, and after it, until inputs act, the latch, mask and pending registers read 0x0000 and `evt_req` is low.
- R2: A rising edge on `evt_in[i]` sets latch bit i after two clock edges. A line that stays high sets it only once.
- R3: A latch bit clears on the edge that sets its pending bit. A rising edge on that line arriving later, or on the same edge, sets the latch bit again and queues the event.
- R4: A write with `reg_sel`=0 changes only the latch bits whose mask bit is 0. Latch bits whose mask bit is 1 keep their value.
- R5: `evt_req` is high exactly when some bit is latched, mask-enabled and the global enable is on, and the lowest such index is below the lowest set pending index (or pending is zero). `evt_req_id` gives that index. Index 0 has the highest priority.
- R6: `evt_req` with `evt_ack` high on a clock edge sets the offered pending bit. The minimum delay from an input rising edge to the pending bit reading 1 is three clock edges.
- R7: A `rti` pulse clears the lowest-index set pending bit and leaves all other pending bits set.
- R8: `gie_set` turns the global enable on and `gie_clr` turns it off; `gie_clr` wins when both are high. While the enable is off no event is offered, and latched events remain latched.
- R9: Reads use `reg_sel` 0=latch, 1=mask, 2=pending, 3=zero. A write with `reg_sel`=2 leaves the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_in | input | 16 | General-purpose event levels |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 latch, 1 mask, 2 pending, 3 none |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| gie_set | input | 1 | Global enable on command |
| gie_clr | input | 1 | Global enable off command |
| evt_ack | input | 1 | Pipeline accepts the offered event |
| rti | input | 1 | Return from interrupt: retire the innermost event |
| evt_req | output | 1 | An event is offered to the pipeline |
| evt_req_id | output | 4 | Index of the offered event |

## Verification
The bench targets a re-edge on a line whose event is still pending. A design that forgot to queue it would lose the event, and one that ignored the pending comparison would re-offer the same level as a nested event. It times the edge-to-pending path, where an extra or missing stage shows up as a latency other than three. It writes the latch under a partial mask, where a design that did not guard the write would destroy or forge events. It also checks that `rti` retires only the innermost of two nested events and that a simultaneous enable/disable leaves the controller disabled. Random traffic compares every cycle against a bench model of the requirements.

// File: rtl/enc_pkg.sv
`timescale 1ns/1ps
package enc_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/enc_rst_sync.sv
`timescale 1ns/1ps
module enc_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/enc_edge_det.sv
`timescale 1ns/1ps
module enc_edge_det #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] stg1_q, stg2_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        stg1_q[g] <= 1'b0;
        stg2_q[g] <= 1'b0;
      end else begin
        stg1_q[g] <= lvl_i[g];
        stg2_q[g] <= stg1_q[g];
      end
    end
    assign rise_o[g] = stg1_q[g] & ~stg2_q[g];
  end

  // R2: a detected edge lasts one cycle only
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (rise_o & $past(rise_o)) == '0);
endmodule

// File: rtl/enc_first_set.sv
`timescale 1ns/1ps
module enc_first_set #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  oh_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
    oh_o = '0;
    if (any_o) oh_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/enc_pend_track.sv
`timescale 1ns/1ps
module enc_pend_track #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [N-1:0]  acc_oh_i,
  input  logic          rti_i,
  output logic [N-1:0]  pend_o,
  output logic          top_any_o,
  output logic [IW-1:0] top_idx_o
);
  logic [N-1:0] pend_q, pend_d, top_oh, ret_oh;
  logic         pend_en;

  enc_first_set #(.N(N), .IW(IW)) u_top (
    .vec_i (pend_q),
    .any_o (top_any_o),
    .idx_o (top_idx_o),
    .oh_o  (top_oh)
  );

  always_comb begin
    ret_oh  = rti_i ? top_oh : '0;
    pend_en = (|ret_oh) | (|acc_oh_i);
    pend_d  = (pend_q & ~ret_oh) | acc_oh_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R7: a return with no accept removes exactly one pending bit
  assert_rti_retires_one_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (rti_i && pend_q != '0 && acc_oh_i == '0) |=>
      ($countones(pend_q) + 1 == $countones($past(pend_q))));
  // R7: bits above the innermost one survive a return
  assert_rti_keeps_outer_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    rti_i |=> ((($past(pend_q) & ~$past(top_oh)) & ~pend_q) == '0));
endmodule

// File: rtl/evt_nest_ctrl.sv
`timescale 1ns/1ps
module evt_nest_ctrl #(
  parameter int NUM_EVT = 16,
  parameter int IDW     = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               reg_wr,
  input  logic [1:0]         reg_sel,
  input  logic [NUM_EVT-1:0] reg_wdata,
  output logic [NUM_EVT-1:0] reg_rdata,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               evt_ack,
  input  logic               rti,
  output logic               evt_req,
  output logic [IDW-1:0]     evt_req_id
);
  import enc_pkg::*;

  logic               rst_ni;
  logic [NUM_EVT-1:0] rise_w;
  logic [NUM_EVT-1:0] latch_q, latch_d, mask_q, mask_d;
  logic               latch_en, mask_en;
  logic               gie_q, gie_d, gie_en;
  logic [NUM_EVT-1:0] cand_w, cand_oh, acc_oh, pend_w;
  logic               cand_any, pend_any;
  logic [IDW-1:0]     cand_idx, pend_top;
  logic               wr_latch, wr_mask;

  enc_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_ni)
  );

  enc_edge_det #(.N(NUM_EVT)) u_edge (
    .clk    (clk),
    .rst_ni (rst_ni),
    .lvl_i  (evt_in),
    .rise_o (rise_w)
  );

  assign cand_w = latch_q & mask_q & {NUM_EVT{gie_q}};

  enc_first_set #(.N(NUM_EVT), .IW(IDW)) u_cand (
    .vec_i (cand_w),
    .any_o (cand_any),
    .idx_o (cand_idx),
    .oh_o  (cand_oh)
  );

  enc_pend_track #(.N(NUM_EVT), .IW(IDW)) u_pend (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .acc_oh_i  (acc_oh),
    .rti_i     (rti),
    .pend_o    (pend_w),
    .top_any_o (pend_any),
    .top_idx_o (pend_top)
  );

  // offer and accept
  always_comb begin
    evt_req    = cand_any && (!pend_any || (cand_idx < pend_top));
    evt_req_id = cand_idx;
    acc_oh     = (evt_req && evt_ack) ? cand_oh : '0;
  end

  // next state for latch, mask and enable
  always_comb begin
    wr_latch = reg_wr && (reg_sel == SEL_LATCH);
    wr_mask  = reg_wr && (reg_sel == SEL_MASK);

    latch_d = latch_q;
    if (wr_latch) latch_d = (latch_q & mask_q) | (reg_wdata & ~mask_q);
    latch_d  = (latch_d & ~acc_oh) | rise_w;
    latch_en = wr_latch | (|acc_oh) | (|rise_w);

    mask_d  = reg_wdata;
    mask_en = wr_mask;

    gie_d  = gie_clr ? 1'b0 : 1'b1;
    gie_en = gie_set | gie_clr;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      mask_q  <= '0;
      gie_q   <= 1'b0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      if (mask_en)  mask_q  <= mask_d;
      if (gie_en)   gie_q   <= gie_d;
    end
  end

  // read mux
  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_LATCH: reg_rdata = latch_q;
      SEL_MASK:  reg_rdata = mask_q;
      SEL_PEND:  reg_rdata = pend_w;
      default:   reg_rdata = '0;
    endcase
  end

  // R3: an accepted event leaves the latch unless a new edge queues it
  assert_latch_clr_on_acc_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_req && evt_ack) |=> ((latch_q & $past(acc_oh) & ~$past(rise_w)) == '0));
  // R4: latch writes leave mask-enabled bits alone
  assert_latch_wr_guard_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_latch |=> (((latch_q ^ $past(latch_q)) & $past(mask_q)
                   & ~$past(rise_w) & ~$past(acc_oh)) == '0));
  // R5: the offered event is latched and not already in service
  assert_offer_valid_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    evt_req |-> (latch_q[evt_req_id] && !pend_w[evt_req_id]));
  // R6: acknowledgement sets the offered pending bit
  assert_ack_sets_pend_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_req && evt_ack) |=> pend_w[$past(evt_req_id)]);
  // R8: a disable command stops all offers on the next cycle
  assert_disable_blocks_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    gie_clr |=> !evt_req);
  // R9: pending writes do nothing on their own
  assert_pend_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_sel == SEL_PEND && !rti && !(evt_req && evt_ack)) |=> $stable(pend_w));
endmodule

// File: tb/test_evt_nest_ctrl.sv
`timescale 1ns/1ps
module test_evt_nest_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt_in;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        gie_set, gie_clr, evt_ack, rti;
  logic        evt_req;
  logic [3:0]  evt_req_id;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model state
  logic [15:0] m_lat, m_msk, m_pnd, m_s1, m_s2;
  logic        m_gie;

  always #5 clk = ~clk;

  evt_nest_ctrl i_evt_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie_set(gie_set), .gie_clr(gie_clr),
    .evt_ack(evt_ack), .rti(rti), .evt_req(evt_req), .evt_req_id(evt_req_id)
  );

  function automatic int first_bit(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return 16;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; gie_set = 0; gie_clr = 0; rti = 0;
  endtask

  // one cycle: check outputs against the model, then advance the model
  task automatic step();
    logic [15:0] rise, cand, acc, ret, nl, exp_rd;
    int c, t;
    bit req;
    @(negedge clk);
    #1;
    rise = m_s1 & ~m_s2;
    cand = m_lat & m_msk & {16{m_gie}};
    c = first_bit(cand);
    t = first_bit(m_pnd);
    req = (c < 16) && (c < t);
    chk(evt_req == req, "R5 req", 32'(evt_req), 32'(req));
    if (req) chk(evt_req_id == 4'(c), "R5 id", 32'(evt_req_id), 32'(c));
    case (reg_sel)
      2'd0: exp_rd = m_lat;
      2'd1: exp_rd = m_msk;
      2'd2: exp_rd = m_pnd;
      default: exp_rd = 16'h0;
    endcase
    chk(reg_rdata == exp_rd, "R9 rdata", 32'(reg_rdata), 32'(exp_rd));
    acc = (req && evt_ack) ? (16'h1 << c) : 16'h0;
    ret = (rti && t < 16) ? (16'h1 << t) : 16'h0;
    nl  = m_lat;
    if (reg_wr && reg_sel == 2'd0) nl = (m_lat & m_msk) | (reg_wdata & ~m_msk);
    nl = (nl & ~acc) | rise;
    @(posedge clk);
    #1;
    m_lat = nl;
    if (reg_wr && reg_sel == 2'd1) m_msk = reg_wdata;
    m_pnd = (m_pnd & ~ret) | acc;
    if (gie_clr) m_gie = 1'b0; else if (gie_set) m_gie = 1'b1;
    m_s2 = m_s1;
    m_s1 = evt_in;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'd4242));
    rst_n = 0; evt_in = 0; reg_sel = 0; reg_wdata = 0; evt_ack = 0;
    idle();
    m_lat = 0; m_msk = 0; m_pnd = 0; m_s1 = 0; m_s2 = 0; m_gie = 0;
    repeat (3) @(posedge clk);
    // R1: reset state
    for (int s = 0; s < 3; s++) begin
      @(negedge clk); reg_sel = 2'(s); #1;
      chk(reg_rdata == 16'h0, "R1 reset rdata", 32'(reg_rdata), 0);
    end
    chk(evt_req == 1'b0, "R1 reset req", 32'(evt_req), 0);
    @(negedge clk); rst_n = 1;
    reg_sel = 2'd2;
    repeat (4) step();

    // R6: edge-to-pending latency
    reg_wr = 1; reg_sel = 2'd1; reg_wdata = 16'h0020; gie_set = 1;
    step(); idle(); reg_sel = 2'd2;
    evt_ack = 1; evt_in[5] = 1'b1;
    lat = 0;
    for (int k = 0; k < 8; k++) begin
      step(); lat++;
      if (reg_rdata[5]) break;
    end
    chk(lat == 3, "R6 latency", 32'(lat), 3);

    // R3: queued re-edge while pending, then resume after return
    evt_ack = 0; evt_in[5] = 1'b0; step();
    evt_in[5] = 1'b1; step(); step();
    reg_sel = 2'd0; step();
    chk(reg_rdata[5] == 1'b1, "R3 queued latch", 32'(reg_rdata), 32'h20);
    chk(evt_req == 1'b0, "R3 no self nest", 32'(evt_req), 0);
    rti = 1; step(); idle();
    chk(evt_req == 1'b1 && evt_req_id == 4'd5, "R3 re-offer", 32'(evt_req_id), 5);
    evt_ack = 1; step(); evt_ack = 0;
    chk(reg_rdata[5] == 1'b0, "R3 latch cleared", 32'(reg_rdata), 0);
    // R2: level held high does not re-latch
    repeat (3) step();
    chk(reg_rdata == 16'h0, "R2 held level", 32'(reg_rdata), 0);

    // R4: guarded latch writes
    reg_wr = 1; reg_sel = 2'd0; reg_wdata = 16'hFFFF; step(); idle();
    chk(reg_rdata == 16'hFFDF, "R4 write masked", 32'(reg_rdata), 32'hFFDF);
    reg_wr = 1; reg_wdata = 16'h0000; step(); idle();
    chk(reg_rdata == 16'h0000, "R4 write clear", 32'(reg_rdata), 0);

    // R9: pending write ignored
    reg_wr = 1; reg_sel = 2'd2; reg_wdata = 16'hFFFF; step(); idle();
    chk(reg_rdata == 16'h0020, "R9 pend readonly", 32'(reg_rdata), 32'h20);

    // R7: nesting and return
    reg_wr = 1; reg_sel = 2'd1; reg_wdata = 16'hFFFF; step(); idle();
    reg_sel = 2'd2; evt_ack = 1; evt_in[3] = 1'b1;
    repeat (4) step();
    chk(reg_rdata == 16'h0028, "R7 nested", 32'(reg_rdata), 32'h28);
    evt_ack = 0; rti = 1; step(); idle();
    chk(reg_rdata == 16'h0020, "R7 inner retired", 32'(reg_rdata), 32'h20);
    rti = 1; step(); idle();
    chk(reg_rdata == 16'h0000, "R7 outer retired", 32'(reg_rdata), 0);

    // R8: clear wins, latched event waits
    gie_set = 1; gie_clr = 1; step(); idle();
    evt_ack = 1; evt_in[2] = 1'b1;
    repeat (4) step();
    chk(reg_rdata == 16'h0000 && !evt_req, "R8 disabled", 32'(reg_rdata), 0);
    evt_ack = 0; gie_set = 1; step(); idle();
    chk(evt_req == 1'b1 && evt_req_id == 4'd2, "R8 enabled offer", 32'(evt_req_id), 2);

    // random traffic against the model (R2..R9)
    for (int n = 0; n < 4000; n++) begin
      evt_in    = evt_in ^ 16'($urandom & $urandom & $urandom);
      evt_ack   = $urandom_range(1, 0) == 1;
      rti       = $urandom_range(7, 0) == 0;
      reg_wr    = $urandom_range(7, 0) == 0;
      reg_sel   = 2'($urandom_range(3, 0));
      reg_wdata = (reg_sel == 2'd1) ? 16'($urandom | $urandom) : 16'($urandom);
      gie_set   = $urandom_range(15, 0) == 0;
      gie_clr   = $urandom_range(31, 0) == 0;
      step();
    end
    idle();
    done = 1;
    summary();
    $finish;
  end
endmodule